// File: doc/BRIEF.md
# Indirect TLB Entry Access Port

This block gives software a window onto the entries of a small set-associative translation buffer. Software never addresses an entry directly. It programs a select register with a way and an index. Each hi-word write is copied into a cause register. A lo-word write then commits both words into the selected entry in one step. Reads refresh the staged hi and lo registers from the selected entry before returning, so software always sees the live entry contents.

A 2-bit bank selector, taken from the low bits of a status register, chooses one of four special-register banks. Each bank holds sixteen 32-bit registers. Banks 1 and 2 each own a separate entry array of 4 ways by 16 entries. Bank 1 uses array 0 and bank 2 uses array 1. Banks 0 and 3 are plain register storage. When a commit overwrites an entry whose valid bit was set, the block raises a one-cycle flush request. The request carries the old entry's page address, so any cached copy of the old mapping can be dropped. Lookup, miss handling and table walking are not part of this block.

A small controller holds one of three states, and the state register drives the output strobes. ST_IDLE means nothing is reported. ST_RDATA means read data is presented. ST_FLUSH means a flush request is presented. Every cycle the controller takes one of three transitions. It takes the commit-flush transition into ST_FLUSH when a lo commit finds the old entry valid. Otherwise it takes the read-accept transition into ST_RDATA when a read is accepted. In every other case it takes the quiet transition into ST_IDLE. These transitions apply from every state.

Top module: `tlbwin_port`

## Requirements
- R1: After reset, rd_valid and flush_valid are 0, all special registers read as 0, and every entry in both arrays is zero, which means invalid.
- R2: A read of register number n in bank b returns the value last stored there. The bank is bank_sel. Each bank keeps its own 16 registers.
- R3: In bank 1 or 2, writing register 6 (the hi word) also stores the same value into register 7 (the cause register).
- R4: In bank 1 or 2, writing register 5 (the lo word) commits the entry chosen by register 4 of that bank. The way is bits [5:4] and the index is bits [3:0]. Array 0 is used for bank 1 and array 1 for bank 2. The entry's lo word takes the written data and its hi word takes the current register 7 value.
- R5: Suppose the entry overwritten by an R4 commit had lo bit 3 set. Then flush_valid is 1 in the cycle after the write, for one cycle, and flush_addr equals the old hi word with bits [12:0] cleared. If that bit was clear, no flush is raised.
- R6: An accepted read in bank 1 or 2 first copies the selected entry's lo word into register 5 and its hi word into register 6. It then returns the requested register. Reading 5 or 6 therefore returns the entry contents.
- R7: In banks 0 and 3, writes to registers 5 and 6 only store the value. They touch no entry, leave register 7 alone and never raise a flush.
- R8: A read request in a cycle that also has wr_en high is ignored. No rd_valid follows.
- R9: An accepted read (rd_en high, wr_en low) gives rd_valid high with rd_data in the next cycle. rd_valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Register bank select, the low bits of the status register |
| wr_en | input | 1 | Special-register write strobe |
| wr_num | input | 4 | Register number written |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Special-register read strobe |
| rd_num | input | 4 | Register number read |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | rd_data is valid this cycle |
| flush_valid | output | 1 | One-cycle request to drop a stale mapping |
| flush_addr | output | 32 | Page address of the mapping to drop |

## Verification
The assertions assume that bank_sel, wr_num and the strobes are defined and stable at each rising edge. They also assume that a flush can only follow a lo-word write made in bank 1 or 2. The stimulus drives every input at the falling edge. It draws banks from all four values and biases register numbers toward the select, lo, hi and cause registers, so commits, flushes and refreshes happen often. Random lo data sets the valid bit about half the time. Directed cases cover the states after reset, the separation between the two arrays, and reads that arrive in the same cycle as a write.

// File: rtl/tlbwin_pkg.sv
package tlbwin_pkg;

    // Special-register numbers whose side effects define the window.
    parameter int unsigned SR_SEL   = 4;
    parameter int unsigned SR_LO    = 5;
    parameter int unsigned SR_HI    = 6;
    parameter int unsigned SR_CAUSE = 7;

    // Controller state: which output strobe is presented this cycle.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RDATA = 2'd1,
        ST_FLUSH = 2'd2
    } win_state_t;

endpackage

// File: rtl/tlbwin_ctrl.sv
module tlbwin_ctrl
    import tlbwin_pkg::*;
#(
    parameter int BANK_SEL_W = 2,
    parameter int REG_NUM_W  = 4,
    parameter int NUM_ARR    = 2,
    parameter int ARR_W      = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BANK_SEL_W-1:0] bank_sel,
    input  logic                  wr_en,
    input  logic [REG_NUM_W-1:0]  wr_num,
    input  logic                  rd_en,
    input  logic                  old_valid,
    output logic                  tlb_bank,
    output logic [ARR_W-1:0]      arr_idx,
    output logic                  hi_side,
    output logic                  lo_commit,
    output logic                  refresh,
    output logic                  rd_accept,
    output logic                  flush_load,
    output logic                  rd_valid,
    output logic                  flush_valid
);

    win_state_t state_q, state_d;
    logic [BANK_SEL_W-1:0] bank_m1;

    // Bank decode: banks 1..NUM_ARR reach array (bank - 1).
    always_comb begin
        bank_m1   = bank_sel - BANK_SEL_W'(1);
        tlb_bank  = (bank_sel != '0) && (32'(bank_m1) < NUM_ARR);
        arr_idx   = ARR_W'(bank_m1);
        rd_accept = rd_en && !wr_en;
        hi_side   = wr_en && tlb_bank && (wr_num == REG_NUM_W'(SR_HI));
        lo_commit = wr_en && tlb_bank && (wr_num == REG_NUM_W'(SR_LO));
        refresh   = rd_accept && tlb_bank;
        flush_load = lo_commit && old_valid;
    end

    // Transitions: commit-flush, read-accept, quiet (from any state).
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RDATA, ST_FLUSH: begin
                if (flush_load)
                    state_d = ST_FLUSH;
                else if (rd_accept)
                    state_d = ST_RDATA;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output strobes decoded from the state register.
    always_comb begin
        rd_valid    = 1'b0;
        flush_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RDATA: rd_valid    = 1'b1;
            ST_FLUSH: flush_valid = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/tlbwin_sreg_file.sv
module tlbwin_sreg_file
    import tlbwin_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int REG_NUM_W   = 4,
    parameter int BANK_SEL_W  = 2,
    parameter int SEL_FIELD_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BANK_SEL_W-1:0]  bank,
    input  logic                   wr_en,
    input  logic [REG_NUM_W-1:0]   wr_num,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   cause_we,
    input  logic                   refresh_we,
    input  logic [DATA_W-1:0]      mir_hi,
    input  logic [DATA_W-1:0]      mir_lo,
    input  logic [REG_NUM_W-1:0]   rd_num,
    output logic [DATA_W-1:0]      rd_word,
    output logic [SEL_FIELD_W-1:0] sel_field,
    output logic [DATA_W-1:0]      cause_word
);

    localparam int IDX_W = BANK_SEL_W + REG_NUM_W;
    localparam int TOTAL = 1 << IDX_W;

    logic [DATA_W-1:0] regs [TOTAL];
    logic [DATA_W-1:0] sel_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++)
                regs[i] <= '0;
        end else begin
            if (wr_en)
                regs[{bank, wr_num}] <= wr_data;
            if (cause_we)
                regs[{bank, REG_NUM_W'(SR_CAUSE)}] <= wr_data;
            if (refresh_we) begin
                regs[{bank, REG_NUM_W'(SR_LO)}] <= mir_lo;
                regs[{bank, REG_NUM_W'(SR_HI)}] <= mir_hi;
            end
        end
    end

    always_comb begin
        rd_word    = regs[{bank, rd_num}];
        sel_word   = regs[{bank, REG_NUM_W'(SR_SEL)}];
        sel_field  = sel_word[SEL_FIELD_W-1:0];
        cause_word = regs[{bank, REG_NUM_W'(SR_CAUSE)}];
    end

endmodule

// File: rtl/tlbwin_entry_array.sv
module tlbwin_entry_array #(
    parameter int DATA_W    = 32,
    parameter int NUM_ARR   = 2,
    parameter int ARR_W     = 1,
    parameter int SLOT_W    = 6,
    parameter int VALID_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ARR_W-1:0]  arr_sel,
    input  logic [SLOT_W-1:0] slot,
    input  logic              we,
    input  logic [DATA_W-1:0] wr_hi,
    input  logic [DATA_W-1:0] wr_lo,
    output logic [DATA_W-1:0] rd_hi,
    output logic [DATA_W-1:0] rd_lo,
    output logic              old_valid
);

    localparam int SLOTS = 1 << SLOT_W;

    logic [DATA_W-1:0] arr_hi [NUM_ARR];
    logic [DATA_W-1:0] arr_lo [NUM_ARR];

    for (genvar g = 0; g < NUM_ARR; g++) begin : g_arr
        logic [DATA_W-1:0] hi_mem [SLOTS];
        logic [DATA_W-1:0] lo_mem [SLOTS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < SLOTS; i++) begin
                    hi_mem[i] <= '0;
                    lo_mem[i] <= '0;
                end
            end else if (we && (arr_sel == ARR_W'(g))) begin
                hi_mem[slot] <= wr_hi;
                lo_mem[slot] <= wr_lo;
            end
        end

        assign arr_hi[g] = hi_mem[slot];
        assign arr_lo[g] = lo_mem[slot];
    end

    always_comb begin
        rd_hi     = arr_hi[arr_sel];
        rd_lo     = arr_lo[arr_sel];
        old_valid = rd_lo[VALID_BIT];
    end

endmodule

// File: rtl/tlbwin_port.sv
module tlbwin_port
    import tlbwin_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int REG_NUM_W  = 4,
    parameter int BANK_SEL_W = 2,
    parameter int NUM_ARR    = 2,
    parameter int WAY_W      = 2,
    parameter int IDX_W      = 4,
    parameter int PAGE_SHIFT = 13,
    parameter int VALID_BIT  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BANK_SEL_W-1:0] bank_sel,
    input  logic                  wr_en,
    input  logic [REG_NUM_W-1:0]  wr_num,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_en,
    input  logic [REG_NUM_W-1:0]  rd_num,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_valid,
    output logic                  flush_valid,
    output logic [DATA_W-1:0]     flush_addr
);

    localparam int SLOT_W = WAY_W + IDX_W;
    localparam int ARR_W  = (NUM_ARR > 1) ? $clog2(NUM_ARR) : 1;
    localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1));

    logic              tlb_bank, hi_side, lo_commit, refresh, rd_accept, flush_load;
    logic              old_valid;
    logic [ARR_W-1:0]  arr_idx;
    logic [SLOT_W-1:0] sel_field;
    logic [DATA_W-1:0] sreg_word, cause_word, ent_hi, ent_lo, rd_next;

    tlbwin_ctrl #(
        .BANK_SEL_W (BANK_SEL_W),
        .REG_NUM_W  (REG_NUM_W),
        .NUM_ARR    (NUM_ARR),
        .ARR_W      (ARR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bank_sel    (bank_sel),
        .wr_en       (wr_en),
        .wr_num      (wr_num),
        .rd_en       (rd_en),
        .old_valid   (old_valid),
        .tlb_bank    (tlb_bank),
        .arr_idx     (arr_idx),
        .hi_side     (hi_side),
        .lo_commit   (lo_commit),
        .refresh     (refresh),
        .rd_accept   (rd_accept),
        .flush_load  (flush_load),
        .rd_valid    (rd_valid),
        .flush_valid (flush_valid)
    );

    tlbwin_sreg_file #(
        .DATA_W      (DATA_W),
        .REG_NUM_W   (REG_NUM_W),
        .BANK_SEL_W  (BANK_SEL_W),
        .SEL_FIELD_W (SLOT_W)
    ) u_sregs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank       (bank_sel),
        .wr_en      (wr_en),
        .wr_num     (wr_num),
        .wr_data    (wr_data),
        .cause_we   (hi_side),
        .refresh_we (refresh),
        .mir_hi     (ent_hi),
        .mir_lo     (ent_lo),
        .rd_num     (rd_num),
        .rd_word    (sreg_word),
        .sel_field  (sel_field),
        .cause_word (cause_word)
    );

    tlbwin_entry_array #(
        .DATA_W    (DATA_W),
        .NUM_ARR   (NUM_ARR),
        .ARR_W     (ARR_W),
        .SLOT_W    (SLOT_W),
        .VALID_BIT (VALID_BIT)
    ) u_entries (
        .clk       (clk),
        .rst_n     (rst_n),
        .arr_sel   (arr_idx),
        .slot      (sel_field),
        .we        (lo_commit),
        .wr_hi     (cause_word),
        .wr_lo     (wr_data),
        .rd_hi     (ent_hi),
        .rd_lo     (ent_lo),
        .old_valid (old_valid)
    );

    // Read data: staged words come straight from the entry on a refresh.
    always_comb begin
        if (refresh && (rd_num == REG_NUM_W'(SR_LO)))
            rd_next = ent_lo;
        else if (refresh && (rd_num == REG_NUM_W'(SR_HI)))
            rd_next = ent_hi;
        else
            rd_next = sreg_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data    <= '0;
            flush_addr <= '0;
        end else begin
            if (rd_accept)
                rd_data <= rd_next;
            if (flush_load)
                flush_addr <= ent_hi & PAGE_MASK;
        end
    end

endmodule

// File: rtl/tlbwin_checker.sv
module tlbwin_checker #(
    parameter int DATA_W     = 32,
    parameter int REG_NUM_W  = 4,
    parameter int BANK_SEL_W = 2,
    parameter int PAGE_SHIFT = 13
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [BANK_SEL_W-1:0] bank_sel,
    input logic                  wr_en,
    input logic [REG_NUM_W-1:0]  wr_num,
    input logic                  rd_en,
    input logic                  rd_valid,
    input logic                  flush_valid,
    input logic [DATA_W-1:0]     flush_addr
);

    logic lo_wr_tlb;
    assign lo_wr_tlb = wr_en && (wr_num == REG_NUM_W'(5)) &&
                       ((bank_sel == BANK_SEL_W'(1)) || (bank_sel == BANK_SEL_W'(2)));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !flush_valid));

    assert_read_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rd_valid);

    assert_read_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && !wr_en));

    assert_write_blocks_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !rd_valid);

    assert_flush_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> $past(lo_wr_tlb));

    assert_flush_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (flush_addr[PAGE_SHIFT-1:0] == '0));

    assert_plain_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((bank_sel == BANK_SEL_W'(0)) || (bank_sel == BANK_SEL_W'(3)))) |=> !flush_valid);

    assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, flush_valid}));

endmodule

bind tlbwin_port tlbwin_checker #(
    .DATA_W     (DATA_W),
    .REG_NUM_W  (REG_NUM_W),
    .BANK_SEL_W (BANK_SEL_W),
    .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_sel    (bank_sel),
    .wr_en       (wr_en),
    .wr_num      (wr_num),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .flush_valid (flush_valid),
    .flush_addr  (flush_addr)
);

// File: tb/tb_tlbwin_port.sv
module tb_tlbwin_port;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  bank_sel;
    logic        wr_en, rd_en;
    logic [3:0]  wr_num, rd_num;
    logic [31:0] wr_data, rd_data, flush_addr;
    logic        rd_valid, flush_valid;

    always #10 clk = ~clk;

    tlbwin_port dut (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
        .rd_en(rd_en), .rd_num(rd_num), .rd_data(rd_data), .rd_valid(rd_valid),
        .flush_valid(flush_valid), .flush_addr(flush_addr)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [31:0] m_sr [4][16];
    logic [31:0] m_hi [2][64];
    logic [31:0] m_lo [2][64];

    function automatic logic [31:0] page_of(logic [31:0] hi);
        return hi & 32'hFFFF_E000;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int b = 0; b < 4; b++)
            for (int n = 0; n < 16; n++) m_sr[b][n] = '0;
        for (int a = 0; a < 2; a++)
            for (int s = 0; s < 64; s++) begin
                m_hi[a][s] = '0;
                m_lo[a][s] = '0;
            end
    endtask

    // One cycle of stimulus with model update and output check.
    task automatic step(bit w, logic [3:0] wn, logic [31:0] wd,
                        bit r, logic [3:0] rn, logic [1:0] b, string dtag);
        int  bi, a, slot;
        bit  tlb, erv, efl;
        logic [31:0] edata, eaddr;
        string rtag;
        @(negedge clk);
        bank_sel = b; wr_en = w; wr_num = wn; wr_data = wd; rd_en = r; rd_num = rn;
        bi = int'(b);
        tlb = (bi == 1) || (bi == 2);
        a = tlb ? bi - 1 : 0;
        slot = int'(m_sr[bi][4][5:0]);
        erv = 1'b0; efl = 1'b0; edata = '0; eaddr = '0;
        if (w) begin
            if (tlb && wn == 4'd5) begin
                efl = m_lo[a][slot][3];
                eaddr = page_of(m_hi[a][slot]);
                m_hi[a][slot] = m_sr[bi][7];
                m_lo[a][slot] = wd;
            end
            m_sr[bi][wn] = wd;
            if (tlb && wn == 4'd6) m_sr[bi][7] = wd;
        end else if (r) begin
            erv = 1'b1;
            if (tlb) begin
                m_sr[bi][5] = m_lo[a][slot];
                m_sr[bi][6] = m_hi[a][slot];
            end
            edata = m_sr[bi][rn];
        end
        @(posedge clk);
        #2;
        check(rd_valid == erv, (w && r) ? "R8 rd_valid" : "R9 rd_valid",
              32'(rd_valid), 32'(erv));
        if (erv) begin
            if (dtag != "") rtag = dtag;
            else if (tlb && (rn == 4'd5 || rn == 4'd6)) rtag = "R6 rd_data";
            else rtag = "R2 rd_data";
            check(rd_data == edata, rtag, rd_data, edata);
        end
        check(flush_valid == efl, tlb ? "R5 flush_valid" : "R7 flush_valid",
              32'(flush_valid), 32'(efl));
        if (efl)
            check(flush_addr == eaddr, "R5 flush_addr", flush_addr, eaddr);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog act=%0d exp=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED_0042);
        rst_n = 1'b0; bank_sel = '0; wr_en = 1'b0; rd_en = 1'b0;
        wr_num = '0; rd_num = '0; wr_data = '0;
        model_clear();
        repeat (3) @(posedge clk);
        #2;
        check(!rd_valid, "R1 reset rd_valid", 32'(rd_valid), 0);
        check(!flush_valid, "R1 reset flush_valid", 32'(flush_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: entries and staged registers start at zero
        step(0, 0, 0, 1, 4'd5, 2'd1, "R1 entry lo");
        step(0, 0, 0, 1, 4'd6, 2'd2, "R1 entry hi");
        step(0, 0, 0, 1, 4'd9, 2'd3, "R1 sreg");

        // R3/R4/R5: bank 1, way 2 index 5
        step(1, 4'd4, 32'h0000_0025, 0, 0, 2'd1, "");
        step(1, 4'd6, 32'hABCD_E123, 0, 0, 2'd1, "");
        step(0, 0, 0, 1, 4'd7, 2'd1, "R3 cause copy");
        step(1, 4'd5, 32'h0000_0008, 0, 0, 2'd1, "");
        step(1, 4'd6, 32'h1111_2000, 0, 0, 2'd1, "");
        step(1, 4'd5, 32'h0000_0008, 0, 0, 2'd1, "");
        step(0, 0, 0, 1, 4'd6, 2'd1, "R4 committed hi");
        step(0, 0, 0, 1, 4'd5, 2'd1, "R4 committed lo");
        step(1, 4'd5, 32'h0000_0000, 0, 0, 2'd1, "");
        step(1, 4'd5, 32'h0000_0008, 0, 0, 2'd1, "");

        // R4: bank 2 reaches a separate array
        step(1, 4'd4, 32'h0000_0025, 0, 0, 2'd2, "");
        step(0, 0, 0, 1, 4'd6, 2'd2, "R4 array separation");
        step(0, 0, 0, 1, 4'd5, 2'd2, "R4 array separation");

        // R7: plain banks have no side effects
        step(1, 4'd6, 32'hDEAD_B000, 0, 0, 2'd0, "");
        step(0, 0, 0, 1, 4'd7, 2'd0, "R7 no cause copy");
        step(1, 4'd5, 32'hFFFF_FFFF, 0, 0, 2'd0, "");
        step(1, 4'd5, 32'hFFFF_FFFF, 0, 0, 2'd0, "");
        step(1, 4'd5, 32'h0000_0008, 0, 0, 2'd3, "");
        step(1, 4'd5, 32'h0000_0008, 0, 0, 2'd3, "");
        step(0, 0, 0, 1, 4'd5, 2'd3, "R7 plain lo");

        // R8: read ignored when it coincides with a write
        step(1, 4'd9, 32'h1234_5678, 1, 4'd9, 2'd1, "");
        step(0, 0, 0, 1, 4'd9, 2'd1, "R2 after collision");

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]  b;
            logic [3:0]  wn, rn;
            logic [31:0] wd;
            int op;
            b  = 2'($urandom_range(0, 3));
            op = int'($urandom_range(0, 7));
            wn = ($urandom_range(0, 3) != 0) ? 4'(4 + $urandom_range(0, 3)) : 4'($urandom_range(0, 15));
            rn = ($urandom_range(0, 3) != 0) ? 4'(4 + $urandom_range(0, 3)) : 4'($urandom_range(0, 15));
            wd = $urandom;
            if (wn == 4'd4) wd = {26'($urandom_range(0, 3)), 6'($urandom_range(0, 63))};
            if (op <= 2)      step(1, wn, wd, 0, rn, b, "");
            else if (op <= 5) step(0, wn, wd, 1, rn, b, "");
            else if (op == 6) step(1, wn, wd, 1, rn, b, "");
            else              step(0, wn, wd, 0, rn, b, "");
        end
        step(0, 0, 0, 0, 0, 2'd0, "");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule